// File: doc/BRIEF.md
# Link-Side Packet Receive Decoder

This block sits on the link side of a parallel interface to a physical-layer device and runs on that interface's clock. Each cycle it samples a 2-bit control bus and an 8-bit data bus. While the PHY owns the bus, the control codes mean the following: 00 is Idle, 01 is Status, 10 is Receive and 11 is Grant. A receive operation opens with one or more Receive cycles that carry the data-on marker, which is a byte with its top bit set. The first Receive cycle whose top bit is clear carries a one-byte speed code. Every Receive cycle after that carries one packet byte. Any cycle that is not Receive closes the operation.

The decoder checks the speed code against the link's configured ceiling. If the packet is accepted, its bytes go out as a registered stream with valid, start-of-packet and end-of-packet markers. If the packet is refused, the decoder raises a one-cycle drop pulse and suppresses all bytes of that packet. Grant cycles are reported on a separate one-cycle pulse. Status cycles produce no output. Every output is registered, so it appears one clock after the bus cycle that causes it.

Top module: `pkt_rx_decoder`

## Requirements
- R1: While rst_ni is low, rx_valid_o, rx_sop_o, rx_eop_o, rx_drop_o and grant_o are 0, and rx_speed_o is 0.
- R2: grant_o is 1 in the cycle after each cycle with ctl_i = 11 and 0 otherwise. Status (ctl_i = 01) never raises any stream output.
- R3: A receive starts only when ctl_i = 10 and data_i[7] = 1. Further data-on cycles (any byte with data_i[7] = 1) may repeat, and none of them is emitted.
- R4: The first later Receive cycle with data_i[7] = 0 is decoded as a speed code. 00xxxxxx gives speed 0, 0100xxxx gives speed 1, and exactly 01010000 gives speed 2. An accepted code is shown on rx_speed_o from the next cycle onward.
- R5: Any other byte with data_i[7] = 0 is an invalid speed. rx_drop_o then pulses for one cycle, one cycle after the speed byte, and no byte of that packet is emitted.
- R6: A valid speed above max_speed_i is rejected in the same way as in R5. max_speed_i 0 allows speed 0 only, 1 allows speeds up to 1, and 2 or 3 allows speeds up to 2.
- R7: For an accepted packet, each Receive cycle after the speed byte gives rx_valid_o = 1 with rx_data_o equal to that byte one cycle later. rx_sop_o is 1 with the first such byte only.
- R8: A non-Receive cycle ends the operation. For an accepted packet, rx_eop_o pulses, with rx_valid_o = 0, one cycle after that ending cycle, including when the packet has no bytes. A rejected packet gets no eop.
- R9: If a non-Receive cycle arrives before any speed byte, nothing is emitted and the decoder waits for a new data-on.
- R10: A Receive cycle with data_i[7] = 0 while the decoder is waiting is ignored, along with the Receive cycles that follow it up to the next non-Receive cycle.
- R11: rx_speed_o holds its value until the next accepted speed code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_i | input | 2 | Control bus driven by the PHY |
| data_i | input | 8 | Data bus driven by the PHY |
| max_speed_i | input | 2 | Highest speed the link accepts |
| rx_valid_o | output | 1 | Packet byte valid |
| rx_data_o | output | 8 | Packet byte |
| rx_sop_o | output | 1 | First byte of the packet |
| rx_eop_o | output | 1 | Packet ended |
| rx_speed_o | output | 2 | Speed of the current packet |
| rx_drop_o | output | 1 | Packet rejected |
| grant_o | output | 1 | Grant seen on the control bus |

## Verification
The end of a packet and a grant can land in the same cycle. This happens when the bus goes straight from a packet byte to the Grant code, so that a single bus cycle both closes the packet and signals a grant. The bench ends some packets directly with Grant or Status and checks that rx_eop_o and grant_o rise together in the following cycle. The behavioural model, checked every clock, decides whether that cycle is judged correct. A start-of-packet that falls right after a zero-gap data-on run, and a drop that falls next to a following data-on, are also provoked by random back-to-back traffic.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SPD_W  = 2;
  localparam int unsigned CTL_W  = 2;

  typedef enum logic [CTL_W-1:0] {
    CTL_IDLE   = 2'b00,
    CTL_STATUS = 2'b01,
    CTL_RECV   = 2'b10,
    CTL_GRANT  = 2'b11
  } ctl_e;

  typedef enum logic [SPD_W-1:0] {
    SPD_S100 = 2'd0,
    SPD_S200 = 2'd1,
    SPD_S400 = 2'd2,
    SPD_RSVD = 2'd3
  } spd_e;

  typedef enum logic [1:0] {
    ST_WAIT,
    ST_ON,
    ST_PAY,
    ST_SKIP
  } rx_st_e;
endpackage

// File: rtl/rx_speed_decode.sv
module rx_speed_decode
  import pkt_rx_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic [DW-1:0]    data_i,
  input  logic [SPD_W-1:0] max_i,
  output logic [SPD_W-1:0] code_o,
  output logic             ok_o
);
  localparam int unsigned MSB = DW - 1;
  localparam logic [DW-1:0] S400_PAT = {4'b0101, {(DW-4){1'b0}}};

  logic valid;
  spd_e code, lim;

  always_comb begin
    code  = SPD_S100;
    valid = 1'b0;
    if (data_i[MSB -: 2] == 2'b00) begin
      code  = SPD_S100;
      valid = 1'b1;
    end else if (data_i[MSB -: 4] == 4'b0100) begin
      code  = SPD_S200;
      valid = 1'b1;
    end else if (data_i == S400_PAT) begin
      code  = SPD_S400;
      valid = 1'b1;
    end
    lim = (max_i == SPD_RSVD) ? SPD_S400 : spd_e'(max_i);
  end

  assign code_o = code;
  assign ok_o   = valid && (code <= lim);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import pkt_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             on_i,
  input  logic             spd_ok_i,
  output logic             byte_o,
  output logic             sop_o,
  output logic             eop_o,
  output logic             drop_o,
  output logic             load_o
);
  rx_st_e st_q, st_d;
  logic   seen_q, seen_d;
  logic   is_rx;

  assign is_rx = (ctl_i == CTL_RECV);

  always_comb begin
    st_d   = st_q;
    seen_d = seen_q;
    byte_o = 1'b0;
    sop_o  = 1'b0;
    eop_o  = 1'b0;
    drop_o = 1'b0;
    load_o = 1'b0;
    unique case (st_q)
      ST_WAIT: if (is_rx) st_d = on_i ? ST_ON : ST_SKIP;
      ST_ON: begin
        if (!is_rx) begin
          st_d = ST_WAIT;
        end else if (!on_i) begin
          if (spd_ok_i) begin
            load_o = 1'b1;
            seen_d = 1'b0;
            st_d   = ST_PAY;
          end else begin
            drop_o = 1'b1;
            st_d   = ST_SKIP;
          end
        end
      end
      ST_PAY: begin
        if (is_rx) begin
          byte_o = 1'b1;
          sop_o  = !seen_q;
          seen_d = 1'b1;
        end else begin
          eop_o = 1'b1;
          st_d  = ST_WAIT;
        end
      end
      ST_SKIP: if (!is_rx) st_d = ST_WAIT;
      default: st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_WAIT;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/rx_out_stage.sv
module rx_out_stage
  import pkt_rx_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_i,
  input  logic             sop_i,
  input  logic             eop_i,
  input  logic             drop_i,
  input  logic             load_i,
  input  logic             grant_i,
  input  logic [DW-1:0]    data_i,
  input  logic [SPD_W-1:0] spd_i,
  output logic             valid_o,
  output logic [DW-1:0]    data_o,
  output logic             sop_o,
  output logic             eop_o,
  output logic             drop_o,
  output logic             grant_o,
  output logic [SPD_W-1:0] spd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      sop_o   <= 1'b0;
      eop_o   <= 1'b0;
      drop_o  <= 1'b0;
      grant_o <= 1'b0;
      spd_o   <= '0;
    end else begin
      valid_o <= byte_i;
      sop_o   <= sop_i;
      eop_o   <= eop_i;
      drop_o  <= drop_i;
      grant_o <= grant_i;
      if (byte_i) data_o <= data_i;
      if (load_i) spd_o  <= spd_i;
    end
  end
endmodule

// File: rtl/pkt_rx_decoder.sv
module pkt_rx_decoder
  import pkt_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CTL_W-1:0]    ctl_i,
  input  logic [BYTE_W-1:0]   data_i,
  input  logic [SPD_W-1:0]    max_speed_i,
  output logic                rx_valid_o,
  output logic [BYTE_W-1:0]   rx_data_o,
  output logic                rx_sop_o,
  output logic                rx_eop_o,
  output logic [SPD_W-1:0]    rx_speed_o,
  output logic                rx_drop_o,
  output logic                grant_o
);
  logic [SPD_W-1:0] spd_code;
  logic spd_ok, byte_s, sop_s, eop_s, drop_s, load_s, grant_s;

  assign grant_s = (ctl_i == CTL_GRANT);

  rx_speed_decode #(.DW(BYTE_W)) u_spd (
    .data_i (data_i),
    .max_i  (max_speed_i),
    .code_o (spd_code),
    .ok_o   (spd_ok)
  );

  rx_frame_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_i    (ctl_i),
    .on_i     (data_i[BYTE_W-1]),
    .spd_ok_i (spd_ok),
    .byte_o   (byte_s),
    .sop_o    (sop_s),
    .eop_o    (eop_s),
    .drop_o   (drop_s),
    .load_o   (load_s)
  );

  rx_out_stage #(.DW(BYTE_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .byte_i  (byte_s),
    .sop_i   (sop_s),
    .eop_i   (eop_s),
    .drop_i  (drop_s),
    .load_i  (load_s),
    .grant_i (grant_s),
    .data_i  (data_i),
    .spd_i   (spd_code),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o),
    .sop_o   (rx_sop_o),
    .eop_o   (rx_eop_o),
    .drop_o  (rx_drop_o),
    .grant_o (grant_o),
    .spd_o   (rx_speed_o)
  );
endmodule

// File: rtl/pkt_rx_decoder_chk.sv
module pkt_rx_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] ctl_i,
  input logic [7:0] data_i,
  input logic [1:0] max_speed_i,
  input logic       rx_valid_o,
  input logic [7:0] rx_data_o,
  input logic       rx_sop_o,
  input logic       rx_eop_o,
  input logic [1:0] rx_speed_o,
  input logic       rx_drop_o,
  input logic       grant_o
);
  // R7
  sop_has_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_sop_o |-> rx_valid_o);

  // R7
  byte_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> ($past(ctl_i) == 2'b10 && $past(data_i) == rx_data_o));

  // R8
  eop_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_eop_o |-> (!rx_valid_o && !rx_drop_o && $past(ctl_i) != 2'b10));

  // R5
  drop_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drop_o |=> !rx_drop_o);

  // R5
  drop_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drop_o |-> ($past(ctl_i) == 2'b10 && !$past(data_i[7])));

  // R2
  grant_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i == 2'b11) |=> grant_o);

  // R2
  grant_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> $past(ctl_i) == 2'b11);

  // R11
  speed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_sop_o) |-> $stable(rx_speed_o));

  // R6
  speed_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_sop_o && $stable(max_speed_i)) |-> (rx_speed_o <= max_speed_i || max_speed_i == 2'b11));

  // R4
  speed_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> rx_speed_o != 2'b11);
endmodule

bind pkt_rx_decoder pkt_rx_decoder_chk chk_i (.*);

// File: tb/pkt_rx_decoder_tb_top.sv
module pkt_rx_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ctl = 2'b00;
  logic [7:0] dat = 8'h00;
  logic [1:0] maxs = 2'd2;
  logic       v, sop, eop, drop, gnt;
  logic [7:0] d;
  logic [1:0] spd;

  int n_checks = 0;
  int n_fail = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_rx_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctl_i(ctl), .data_i(dat), .max_speed_i(maxs),
    .rx_valid_o(v), .rx_data_o(d), .rx_sop_o(sop), .rx_eop_o(eop),
    .rx_speed_o(spd), .rx_drop_o(drop), .grant_o(gnt)
  );

  // reference model: 0 wait, 1 data-on seen, 2 payload, 3 skip to end
  int   mode;
  bit   first;
  bit   e_v, e_sop, e_eop, e_drop, e_gnt;
  bit [7:0] e_d;
  int   e_spd;

  function automatic int spd_of(bit [7:0] b);
    if (b[7:6] == 2'b00) return 0;
    if (b[7:4] == 4'b0100) return 1;
    if (b == 8'h50) return 2;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0; first = 0;
      e_v = 0; e_sop = 0; e_eop = 0; e_drop = 0; e_gnt = 0; e_d = 0; e_spd = 0;
    end else begin
      int sp, lim;
      bit rx;
      rx = (ctl == 2'b10);
      e_v = 0; e_sop = 0; e_eop = 0; e_drop = 0;
      e_gnt = (ctl == 2'b11);
      case (mode)
        0: if (rx) mode = dat[7] ? 1 : 3;
        1: begin
          if (!rx) mode = 0;
          else if (!dat[7]) begin
            sp  = spd_of(dat);
            lim = (maxs == 2'd3) ? 2 : int'(maxs);
            if (sp >= 0 && sp <= lim) begin
              e_spd = sp; mode = 2; first = 1;
            end else begin
              e_drop = 1; mode = 3;
            end
          end
        end
        2: begin
          if (rx) begin
            e_v = 1; e_d = dat; e_sop = first; first = 0;
          end else begin
            e_eop = 1; mode = 0;
          end
        end
        default: if (!rx) mode = 0;
      endcase
    end
  end

  task automatic compare();
    bit bad;
    n_checks++;
    bad = (v != e_v) || (sop != e_sop) || (eop != e_eop) || (drop != e_drop) ||
          (gnt != e_gnt) || (int'(spd) != e_spd) || (e_v && d != e_d);
    if (bad) begin
      n_fail++;
      $display("FAIL %s t=%0t act v%0b s%0b e%0b dr%0b g%0b d%02h sp%0d exp v%0b s%0b e%0b dr%0b g%0b d%02h sp%0d",
               tag, $time, v, sop, eop, drop, gnt, d, spd,
               e_v, e_sop, e_eop, e_drop, e_gnt, e_d, e_spd);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [7:0] b);
    ctl = c; dat = b;
    @(negedge clk);
    compare();
  endtask

  task automatic pkt(input int n_on, input logic [7:0] sb, input int nb, input logic [1:0] endc);
    for (int i = 0; i < n_on; i++) step(2'b10, (i == 0) ? 8'hFF : (8'h80 | 8'($urandom)));
    step(2'b10, sb);
    for (int i = 0; i < nb; i++) step(2'b10, 8'($urandom));
    step(endc, 8'h00);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'b00, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();
    compare();
    rst_n = 1'b1;
    idle(2);

    tag = "R4"; maxs = 2'd2;
    pkt(1, 8'h3A, 4, 2'b00); idle(1);
    pkt(2, 8'h4F, 3, 2'b00); idle(1);
    tag = "R7";
    pkt(3, 8'h50, 6, 2'b00); idle(1);

    tag = "R5";
    pkt(1, 8'h51, 3, 2'b00); idle(1);
    pkt(1, 8'h60, 2, 2'b00); idle(1);

    tag = "R6"; maxs = 2'd1;
    pkt(1, 8'h50, 3, 2'b00); idle(1);
    pkt(1, 8'h41, 2, 2'b00); idle(1);
    maxs = 2'd0;
    pkt(1, 8'h40, 2, 2'b00); idle(1);
    maxs = 2'd3;
    pkt(1, 8'h50, 2, 2'b00); idle(1);

    tag = "R11";
    pkt(1, 8'h05, 3, 2'b00); idle(3);
    step(2'b01, 8'h12); idle(1);

    tag = "R8"; maxs = 2'd2;
    pkt(1, 8'h50, 0, 2'b00); idle(1);
    pkt(1, 8'h10, 3, 2'b11); idle(1);
    pkt(1, 8'h10, 2, 2'b01); idle(1);

    tag = "R9";
    step(2'b10, 8'hFF); step(2'b10, 8'hC3); step(2'b00, 8'h00); idle(1);
    step(2'b10, 8'hFF); step(2'b11, 8'h00); idle(1);

    tag = "R10";
    step(2'b10, 8'h12); step(2'b10, 8'hFF); step(2'b10, 8'h00); step(2'b10, 8'h33);
    step(2'b00, 8'h00); idle(1);

    tag = "R2";
    step(2'b11, 8'h00); step(2'b11, 8'h00); step(2'b01, 8'hAA); step(2'b01, 8'h55); idle(2);

    tag = "R3";
    pkt(5, 8'h20, 2, 2'b00); idle(1);

    tag = "R7";
    for (int k = 0; k < 300; k++) begin
      logic [7:0] sb;
      logic [1:0] ec;
      int sel;
      sel = $urandom_range(0, 5);
      sb = (sel == 0) ? 8'h50 : (sel == 1) ? (8'h40 | 8'($urandom_range(0, 15))) :
           (sel == 2) ? 8'($urandom_range(0, 63)) : (8'($urandom) & 8'h7F);
      ec = 2'($urandom);
      if (ec == 2'b10) ec = 2'b00;
      maxs = 2'($urandom);
      pkt($urandom_range(1, 3), sb, $urandom_range(0, 8), ec);
      if ($urandom_range(0, 1) == 1) idle($urandom_range(1, 2));
    end
    idle(2);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, act hung exp done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule